// File: doc/BRIEF.md
# Two-Route Oblivious Mesh Route Unit

This unit performs the route-computation stage of a router in a K x K two-dimensional mesh. When a packet enters the network at its home node, the unit tosses a pseudo-random coin. The coin sends the packet either horizontally first or vertically first. The result is returned as a route bit, which the injecting logic writes into the head flit. At every later hop the head flit presents that bit again, together with the current node's coordinates and the destination's. The unit then selects one output direction, making at most one dimension change over the whole trip and never stepping away from the destination.

The result is registered at the end of the stage. It is a one-hot output direction plus a mask of the virtual channels the packet may request on that direction. The lower half of the virtual channels carries horizontal-first traffic and the upper half carries vertical-first traffic. This splits each link into two independent dimension-ordered networks, each of which is free of deadlock on its own. Body and tail flits do not recompute anything: they reuse the decision held from their head flit. The later stages (virtual-channel allocation, switch allocation and the crossbar) consume these outputs.

Top module: `mesh_route_unit`

## Requirements
- R1: After synchronous reset, out_valid, out_port, out_vc_mask and out_route_yx are all zero.
- R2: Every output is registered: out_valid equals in_valid from the previous clock edge.
- R3: For a head flit whose current coordinates equal its destination, out_port selects the local port (one-hot code 5'b00001), whatever the route bit says.
- R4: With route bit 0 (horizontal first), a head flit goes east (5'b00010) or west (5'b00100) while the X coordinates differ. Once they match, it goes north (5'b01000) or south (5'b10000).
- R5: With route bit 1 (vertical first), a head flit goes north or south while the Y coordinates differ. Once they match, it goes east or west.
- R6: East means increasing X and north means increasing Y. A packet is never sent away from its destination in either dimension.
- R7: out_vc_mask has ones exactly in the lower NUM_VC/2 positions for route bit 0, and exactly in the upper NUM_VC/2 positions for route bit 1.
- R8: A head flit with in_inject high takes its route bit from a free-running 16-bit maximal-length LFSR. A head flit with in_inject low passes in_route_yx through. Either way the bit used appears on out_route_yx.
- R9: A non-head flit leaves out_port, out_vc_mask and out_route_yx equal to the values set by the latest head flit, whatever coordinates it carries.
- R10: Following the unit hop by hop from source to destination takes exactly the Manhattan distance in hops, with at most one change of dimension.
- R11: Across many injections, both route choices occur in roughly equal numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A flit is presented this cycle |
| in_head | input | 1 | The presented flit is a head flit |
| in_inject | input | 1 | Head flit is entering the network here; draw a fresh route bit |
| in_route_yx | input | 1 | Route bit carried in the head flit (0 horizontal first, 1 vertical first) |
| cur_x | input | log2(K) | X coordinate of this router |
| cur_y | input | log2(K) | Y coordinate of this router |
| dst_x | input | log2(K) | Destination X coordinate |
| dst_y | input | log2(K) | Destination Y coordinate |
| out_valid | output | 1 | Registered flit-valid |
| out_port | output | 5 | One-hot output direction: local, east, west, north, south (bits 0..4) |
| out_vc_mask | output | NUM_VC | Virtual channels the flit may request |
| out_route_yx | output | 1 | Route bit used, to be stored in the head flit |

## Verification
Some properties are checked on every clock: the one-hot direction code, the match between mask half and route bit, the forced local port at the destination, the absence of steps away from the destination, the pass-through of a carried route bit, and the hold across body flits. Other results only the bench scenarios can show. These are the full-trip hop counts and turn counts, which emerge only when successive hops are chained. The balance of the random route choice also needs the bench, because it appears only over hundreds of injections.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;

    localparam int PORT_N = 5;

    typedef enum logic [2:0] {
        DIR_LOCAL = 3'd0,
        DIR_EAST  = 3'd1,
        DIR_WEST  = 3'd2,
        DIR_NORTH = 3'd3,
        DIR_SOUTH = 3'd4
    } dir_idx_e;

    typedef logic [PORT_N-1:0] dir_vec_t;

    typedef struct packed {
        dir_vec_t dir;
        logic     yx;
    } route_pick_t;

    function automatic dir_vec_t dir_onehot(dir_idx_e d);
        return dir_vec_t'(5'b00001 << d);
    endfunction

    // Dimension-ordered choice: yx=0 resolves X first, yx=1 resolves Y first.
    function automatic dir_idx_e choose_dir(logic yx, logic x_ne, logic x_up,
                                            logic y_ne, logic y_up);
        dir_idx_e d;
        if (!x_ne && !y_ne)       d = DIR_LOCAL;
        else if (!yx && x_ne)     d = x_up ? DIR_EAST : DIR_WEST;
        else if (!yx)             d = y_up ? DIR_NORTH : DIR_SOUTH;
        else if (y_ne)            d = y_up ? DIR_NORTH : DIR_SOUTH;
        else                      d = x_up ? DIR_EAST : DIR_WEST;
        return d;
    endfunction

endpackage

// File: rtl/route_lfsr.sv
module route_lfsr #(
    parameter int              WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS = 16'hB400,
    parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst,
    output logic coin
);
    logic [WIDTH-1:0] state;

    always_ff @(posedge clk) begin
        if (rst)           state <= SEED;
        else if (state[0]) state <= (state >> 1) ^ TAPS;
        else               state <= state >> 1;
    end

    assign coin = state[0];
endmodule

// File: rtl/route_dir_select.sv
module route_dir_select
    import mesh_route_pkg::*;
#(
    parameter int COORD_W = 2
) (
    input  logic [COORD_W-1:0] here_x,
    input  logic [COORD_W-1:0] here_y,
    input  logic [COORD_W-1:0] goal_x,
    input  logic [COORD_W-1:0] goal_y,
    input  logic               yx,
    output dir_vec_t           dir
);
    dir_idx_e idx;

    always_comb begin
        idx = choose_dir(yx, here_x != goal_x, goal_x > here_x,
                         here_y != goal_y, goal_y > here_y);
        dir = dir_onehot(idx);
    end
endmodule

// File: rtl/route_vc_mask.sv
module route_vc_mask #(
    parameter int NUM_VC = 8
) (
    input  logic              yx,
    output logic [NUM_VC-1:0] mask
);
    localparam int HALF = NUM_VC / 2;

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        if (v < HALF) begin : g_lo
            assign mask[v] = ~yx;
        end else begin : g_hi
            assign mask[v] = yx;
        end
    end
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
    import mesh_route_pkg::*;
#(
    parameter int K       = 4,
    parameter int NUM_VC  = 8,
    parameter int LFSR_W  = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
    localparam int COORD_W = (K > 1) ? $clog2(K) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_head,
    input  logic               in_inject,
    input  logic               in_route_yx,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output logic               out_valid,
    output logic [PORT_N-1:0]  out_port,
    output logic [NUM_VC-1:0]  out_vc_mask,
    output logic               out_route_yx
);
    logic              coin;
    route_pick_t       pick;
    dir_vec_t          next_dir;
    logic [NUM_VC-1:0] next_mask;

    route_lfsr #(.WIDTH(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk (clk),
        .rst (rst),
        .coin(coin)
    );

    assign pick.yx  = in_inject ? coin : in_route_yx;
    assign pick.dir = next_dir;

    route_dir_select #(.COORD_W(COORD_W)) u_dir (
        .here_x(cur_x),
        .here_y(cur_y),
        .goal_x(dst_x),
        .goal_y(dst_y),
        .yx    (pick.yx),
        .dir   (next_dir)
    );

    route_vc_mask #(.NUM_VC(NUM_VC)) u_mask (
        .yx  (pick.yx),
        .mask(next_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_port     <= '0;
            out_vc_mask  <= '0;
            out_route_yx <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid && in_head) begin
                out_port     <= pick.dir;
                out_vc_mask  <= next_mask;
                out_route_yx <= pick.yx;
            end
        end
    end
endmodule

// File: rtl/mesh_route_checker.sv
module mesh_route_checker #(
    parameter int K       = 4,
    parameter int NUM_VC  = 8,
    parameter int COORD_W = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_head,
    input logic               in_inject,
    input logic               in_route_yx,
    input logic [COORD_W-1:0] cur_x,
    input logic [COORD_W-1:0] cur_y,
    input logic [COORD_W-1:0] dst_x,
    input logic [COORD_W-1:0] dst_y,
    input logic               out_valid,
    input logic [4:0]         out_port,
    input logic [NUM_VC-1:0]  out_vc_mask,
    input logic               out_route_yx
);
    localparam int HALF = NUM_VC / 2;
    localparam logic [NUM_VC-1:0] LO_ONES = NUM_VC'((1 << HALF) - 1);
    localparam logic [NUM_VC-1:0] HI_ONES = ~LO_ONES;

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_valid == $past(in_valid));

    assert_head_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_head) |=> $countones(out_port) == 1);

    assert_local_at_goal_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_head && cur_x == dst_x && cur_y == dst_y)
        |=> out_port == 5'b00001);

    assert_no_backstep_x_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_head && dst_x > cur_x) |=> !out_port[2]);

    assert_no_backstep_y_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_head && dst_y > cur_y) |=> !out_port[4]);

    assert_mask_half_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_head) |=>
        (out_vc_mask == (out_route_yx ? HI_ONES : LO_ONES)));

    assert_carried_bit_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_head && !in_inject) |=> out_route_yx == $past(in_route_yx));

    assert_body_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_head) |=>
        $stable(out_port) && $stable(out_vc_mask) && $stable(out_route_yx));
endmodule

bind mesh_route_unit mesh_route_checker #(
    .K(K), .NUM_VC(NUM_VC), .COORD_W(COORD_W)
) u_route_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_head(in_head),
    .in_inject(in_inject), .in_route_yx(in_route_yx),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .out_valid(out_valid), .out_port(out_port),
    .out_vc_mask(out_vc_mask), .out_route_yx(out_route_yx)
);

// File: tb/mesh_route_unit_test.sv
`timescale 1ns/1ps
module mesh_route_unit_test;
    localparam int K = 4;
    localparam int NUM_VC = 8;
    localparam int CW = 2;
    localparam logic [4:0] P_L = 5'b00001, P_E = 5'b00010, P_W = 5'b00100,
                           P_N = 5'b01000, P_S = 5'b10000;
    localparam logic [7:0] MASK_LO = 8'h0F, MASK_HI = 8'hF0;

    // {yx, cx, cy, dx, dy, expected port}
    localparam int NV = 12;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 2'd1, 2'd1, 2'd3, 2'd2, P_E},
        {1'b0, 2'd3, 2'd1, 2'd0, 2'd3, P_W},
        {1'b0, 2'd2, 2'd0, 2'd2, 2'd3, P_N},
        {1'b0, 2'd2, 2'd3, 2'd2, 2'd0, P_S},
        {1'b0, 2'd1, 2'd2, 2'd1, 2'd2, P_L},
        {1'b1, 2'd1, 2'd1, 2'd3, 2'd2, P_N},
        {1'b1, 2'd3, 2'd3, 2'd0, 2'd0, P_S},
        {1'b1, 2'd0, 2'd2, 2'd3, 2'd2, P_E},
        {1'b1, 2'd3, 2'd2, 2'd0, 2'd2, P_W},
        {1'b1, 2'd0, 2'd0, 2'd0, 2'd0, P_L},
        {1'b0, 2'd0, 2'd0, 2'd3, 2'd3, P_E},
        {1'b1, 2'd0, 2'd0, 2'd3, 2'd3, P_N}
    };

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_head, in_inject, in_route_yx;
    logic [CW-1:0] cur_x, cur_y, dst_x, dst_y;
    logic out_valid;
    logic [4:0] out_port;
    logic [NUM_VC-1:0] out_vc_mask;
    logic out_route_yx;
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    mesh_route_unit #(.K(K), .NUM_VC(NUM_VC)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_head(in_head),
        .in_inject(in_inject), .in_route_yx(in_route_yx),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .out_valid(out_valid), .out_port(out_port),
        .out_vc_mask(out_vc_mask), .out_route_yx(out_route_yx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, then sample at the next falling edge (one register).
    task automatic flit(input logic v, input logic h, input logic inj, input logic yx,
                        input int cx, input int cy, input int dx, input int dy);
        in_valid = v; in_head = h; in_inject = inj; in_route_yx = yx;
        cur_x = CW'(cx); cur_y = CW'(cy); dst_x = CW'(dx); dst_y = CW'(dy);
        @(negedge clk);
    endtask

    task automatic walk(input int sx, input int sy, input int dx, input int dy);
        int x = sx, y = sy, hops = 0, turns = 0, last_dim = -1;
        logic yx = 1'b0;
        for (int step = 0; step < 4 * K; step++) begin
            int dim;
            flit(1'b1, 1'b1, step == 0, yx, x, y, dx, dy);
            if (step == 0) yx = out_route_yx;
            check("R7 walk mask", out_vc_mask, yx ? MASK_HI : MASK_LO);
            if (out_port == P_L) break;
            dim = (out_port == P_E || out_port == P_W) ? 0 : 1;
            if (last_dim != -1 && dim != last_dim) turns++;
            last_dim = dim;
            case (out_port)
                P_E: x++;
                P_W: x--;
                P_N: y++;
                default: y--;
            endcase
            hops++;
        end
        check("R10 hops", hops, ((dx > sx) ? dx - sx : sx - dx) + ((dy > sy) ? dy - sy : sy - dy));
        check("R10 turns<=1", turns <= 1, 1);
        check("R10 arrived", {x[7:0], y[7:0]}, {dx[7:0], dy[7:0]});
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int yx_count;
        rst = 1'b1;
        in_valid = 0; in_head = 0; in_inject = 0; in_route_yx = 0;
        cur_x = 0; cur_y = 0; dst_x = 0; dst_y = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", out_valid, 0);
        check("R1 port", out_port, 0);
        check("R1 mask", out_vc_mask, 0);
        check("R1 yx", out_route_yx, 0);
        rst = 1'b0;

        // Table walk: R3 R4 R5 R7 R8 (carried bit)
        for (int i = 0; i < NV; i++) begin
            flit(1'b1, 1'b1, 1'b0, VEC[i][13], VEC[i][12:11], VEC[i][10:9],
                 VEC[i][8:7], VEC[i][6:5]);
            check("R4/R5/R3 port", out_port, VEC[i][4:0]);
            check("R7 mask", out_vc_mask, VEC[i][13] ? MASK_HI : MASK_LO);
            check("R8 carried bit", out_route_yx, VEC[i][13]);
        end

        // R2 latency
        flit(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 0, 0);
        check("R2 idle", out_valid, 0);
        flit(1'b1, 1'b1, 1'b0, 1'b1, 0, 1, 3, 1);
        check("R2 valid", out_valid, 1);
        check("R6 east up-x", out_port, P_E);

        // R9 body flits keep the head decision
        flit(1'b1, 1'b0, 1'b0, 1'b0, 3, 3, 0, 0);
        check("R9 body port", out_port, P_E);
        check("R9 body mask", out_vc_mask, MASK_HI);
        flit(1'b1, 1'b0, 1'b1, 1'b0, 2, 2, 2, 2);
        check("R9 tail port", out_port, P_E);
        check("R9 tail yx", out_route_yx, 1);

        // R3 local even with route bit 1
        flit(1'b1, 1'b1, 1'b0, 1'b1, 3, 0, 3, 0);
        check("R3 local yx=1", out_port, P_L);

        // R10 full trips
        walk(0, 0, 3, 3);
        walk(3, 0, 0, 3);
        walk(2, 3, 0, 1);
        walk(1, 1, 1, 1);
        walk(3, 2, 0, 2);

        // R11 / R8 random choice balance over many injections
        yx_count = 0;
        for (int n = 0; n < 512; n++) begin
            flit(1'b1, 1'b1, 1'b1, 1'b0, 0, 0, 1, 1);
            if (out_route_yx) yx_count++;
            checks++;
            if (out_vc_mask != (out_route_yx ? MASK_HI : MASK_LO)) begin
                failures++;
                $display("FAIL R7 inject mask actual=%0h expected=%0h",
                         out_vc_mask, out_route_yx ? MASK_HI : MASK_LO);
            end
        end
        check("R11 balance", (yx_count > 200) && (yx_count < 312), 1);
        check("R8 both choices", (yx_count > 0) && (yx_count < 512), 1);

        flit(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule